// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eight interrupt requests, resolves them by fixed priority and raises one interrupt line toward a host processor. Four requests come from user logic and four from the terminal-count outputs of counter/timers. Each request can be blocked by its own mask bit and can be sensed either as a level or as a rising edge. All request inputs pass through a synchronizer before use.

The host configures the block and services requests through a small register interface. It reads a 3-bit vector that names the winning source. That read is the acknowledge: the pending edge bit of the named source is cleared in the same cycle, so no separate clear write is needed. Level-sensed sources stay pending for as long as their input stays high. The returned vector is taken at the read cycle, so a request that arrives during the read does not change the value returned.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 8'hFF (all blocked), the sense register reads 8'h00 (all level), the status register reads 8'h00, `irq_out` is low and a vector read returns 8'h00.
- R2: Source n for n in 0..3 is `user_req[n]`, and source 4+n is `tc_done[n]`. Bit n of the status register (address 2) shows the raw pending state of source n, masked or not.
- R3: A source whose sense bit (address 1) is 0 is pending while its synchronized input is high and stops pending when the input goes low. A vector read does not clear it.
- R4: A source whose sense bit is 1 latches a pending bit on a synchronized rising edge. The bit stays set after the input falls, until a vector read acknowledges that source.
- R5: Mask bit n (address 0, 1 = blocked) removes source n from `irq_out` and from vector resolution. A latched edge stays pending and is serviced once the bit is cleared.
- R6: Among unmasked pending sources the lowest index wins. A read of address 3 returns {valid, 4'b0000, vector}, with valid in bit 7, vector in bits 2:0, and 8'h00 when nothing is active.
- R7: `irq_out` is high exactly when at least one unmasked source is pending.
- R8: A vector read acknowledges only the winning source. Other pending sources remain pending.
- R9: Writes to address 2 and address 3 have no effect on any state.
- R10: `irq_vec` always shows the current winning index, and 0 when nothing is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_req | input | 4 | User request lines, sources 0..3 |
| tc_done | input | 4 | Counter/timer terminal counts, sources 4..7 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 mask, 1 sense, 2 status, 3 vector |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| irq_out | output | 1 | Interrupt request to the host |
| irq_vec | output | 3 | Current winning source index |

## Verification
A single held level checks that level sources cannot be acknowledged away. A short pulse checks that the edge latch outlives its input. Three edges raised together, then drained by repeated vector reads, check the priority order and show that each read clears only the winner. An edge on a masked source separates the hidden-but-kept state from a lost request: the status register shows the bit while `irq_out` stays low, and the request appears as soon as the mask is cleared.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] user_req,
  input  logic [3:0] tc_done,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_out,
  output logic [2:0] irq_vec
);
  localparam int NSRC = 8;
  localparam int VW   = $clog2(NSRC);

  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [NSRC-1:0] prev_q, mask_r, mode_r, edge_pend;
  logic [NSRC-1:0] lvl, rise, pend, active, ack;
  logic [VW-1:0]   win;
  logic            rd_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= {tc_done, user_req};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl    = sync_q[SYNC_STAGES-1];
  assign rise   = lvl & ~prev_q;
  assign pend   = (mode_r & edge_pend) | (~mode_r & lvl);
  assign active = pend & ~mask_r;
  assign irq_out = |active;

  always_comb begin
    win = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (active[i]) win = VW'(i);
  end

  assign irq_vec = win;
  assign rd_vec  = reg_rd && (reg_addr == 2'd3);
  assign ack     = (rd_vec && irq_out) ? (NSRC'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r    <= '1;
      mode_r    <= '0;
      edge_pend <= '0;
      reg_rdata <= '0;
    end else begin
      edge_pend <= ((edge_pend & ~ack) | rise) & mode_r;
      if (reg_wr && reg_addr == 2'd0) mask_r <= reg_wdata;
      if (reg_wr && reg_addr == 2'd1) mode_r <= reg_wdata;
      if (reg_rd) begin
        case (reg_addr)
          2'd0:    reg_rdata <= mask_r;
          2'd1:    reg_rdata <= mode_r;
          2'd2:    reg_rdata <= pend;
          default: reg_rdata <= {irq_out, 4'b0000, win};
        endcase
      end else begin
        reg_rdata <= '0;
      end
    end
  end

  // Latched edges survive every cycle without an acknowledge
  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack == '0) |=> ((edge_pend & $past(edge_pend & mode_r)) == $past(edge_pend & mode_r)));

  assert_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (active[irq_vec] && ((active & ((NSRC'(1) << irq_vec) - NSRC'(1))) == '0)));

  assert_one_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !irq_out) |=> (reg_rdata == 8'h00));

  assert_all_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_r == '1) |-> !irq_out);

  assert_idle_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (irq_vec == '0));
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [3:0] user_req = 0, tc_done = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq_out;
  logic [2:0] irq_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (.clk, .rst_n, .user_req, .tc_done, .reg_wr, .reg_rd,
    .reg_addr, .reg_wdata, .reg_rdata, .irq_out, .irq_vec);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_rd = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    rd(2'd0, d); chk("R1 mask", d, 8'hFF);
    rd(2'd1, d); chk("R1 sense", d, 8'h00);
    rd(2'd2, d); chk("R1 status", d, 8'h00);
    rd(2'd3, d); chk("R1 vector", d, 8'h00);
  endtask

  task automatic t_mapping();
    logic [7:0] d;
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    user_req = 4'b0100; settle();
    rd(2'd2, d); chk("R2 user src2", d, 8'h04);
    tc_done = 4'b0010; settle();
    rd(2'd2, d); chk("R2 tc src5", d, 8'h24);
    user_req = 0; tc_done = 0; settle();
  endtask

  task automatic t_level();
    logic [7:0] d;
    user_req = 4'b0010; settle();
    chk("R7 irq level", {7'b0, irq_out}, 8'h01);
    rd(2'd3, d); chk("R3 first read", d, 8'h81);
    rd(2'd3, d); chk("R3 read not clearing", d, 8'h81);
    user_req = 0; settle();
    chk("R3 irq drop", {7'b0, irq_out}, 8'h00);
    rd(2'd2, d); chk("R3 status drop", d, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    wr(2'd1, 8'hFF);
    tc_done = 4'b0100; repeat (3) @(negedge clk); tc_done = 0; settle();
    rd(2'd2, d); chk("R4 latched", d, 8'h40);
    chk("R7 irq edge", {7'b0, irq_out}, 8'h01);
    rd(2'd3, d); chk("R4 vector", d, 8'h86);
    rd(2'd2, d); chk("R4 cleared", d, 8'h00);
    chk("R7 irq cleared", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    user_req = 4'b1000; tc_done = 4'b1010;
    repeat (3) @(negedge clk); user_req = 0; tc_done = 0; settle();
    chk("R10 vec port", {5'b0, irq_vec}, 8'h03);
    rd(2'd3, d); chk("R6 first winner", d, 8'h83);
    rd(2'd2, d); chk("R8 others kept", d, 8'hA0);
    chk("R10 vec port next", {5'b0, irq_vec}, 8'h05);
    rd(2'd3, d); chk("R6 second winner", d, 8'h85);
    rd(2'd3, d); chk("R6 third winner", d, 8'h87);
    rd(2'd3, d); chk("R6 empty read", d, 8'h00);
    chk("R10 idle vec", {5'b0, irq_vec}, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(2'd0, 8'h10);
    tc_done = 4'b0001; repeat (3) @(negedge clk); tc_done = 0; settle();
    chk("R5 irq hidden", {7'b0, irq_out}, 8'h00);
    rd(2'd3, d); chk("R5 vector hidden", d, 8'h00);
    rd(2'd2, d); chk("R5 pending kept", d, 8'h10);
    wr(2'd0, 8'h00);
    chk("R5 irq after unmask", {7'b0, irq_out}, 8'h01);
    rd(2'd3, d); chk("R5 serviced", d, 8'h84);
    rd(2'd2, d); chk("R5 cleared", d, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd2, d); chk("R9 status", d, 8'h00);
    chk("R9 irq", {7'b0, irq_out}, 8'h00);
    rd(2'd0, d); chk("R9 mask", d, 8'h00);
    rd(2'd1, d); chk("R9 sense", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_level();
    t_edge();
    t_prio();
    t_mask();
    t_ignored();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule